// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A byte is written into a one-entry holding register with a load strobe. When the shift stage is idle, the clear-to-send input is active and no break is requested, the byte moves into the shift stage. The holding register is then free for the next byte while the current frame goes out.

The frame shape comes from a 3-bit word-select code. It sets 7 or 8 data bits, even, odd or no parity, and one or two stop bits. The bit period is a whole number of clock-enable ticks: 1, 16 or 64, chosen by a 2-bit divide code. The fourth divide code holds the block in reset. A break request pulls the line to the space level for as long as it stays high.

Top module: `sertx_top`

## Requirements
- R1: While `rst` is high, or while `div_sel` is 2'b11, the block is held in reset. In reset `txd` is 1 (unless `brk` is high), `tx_empty` is 1 and `tx_busy` is 0, and any pending byte or frame in progress is dropped.
- R2: The line idles at 1. A frame is a start bit of 0, then the data bits least significant first, then the parity bit if the format has one, then the stop bits at 1. `txd` shows the start bit from the clock edge at which `tx_busy` rises.
- R3: `word_sel` 3'b000 gives 7 data bits, even parity and 2 stops. 3'b001 gives 7 data bits, odd parity and 2 stops. 3'b010 gives 7 data bits, even parity and 1 stop. 3'b011 gives 7 data bits, odd parity and 1 stop. With 7 data bits, `din[7]` is not sent.
- R4: `word_sel` 3'b100 gives 8 data bits, no parity and 2 stops. 3'b101 gives 8 data bits, no parity and 1 stop. 3'b110 gives 8 data bits, even parity and 1 stop. 3'b111 gives 8 data bits, odd parity and 1 stop.
- R5: The parity bit makes the number of ones across the data bits and the parity bit even (even parity) or odd (odd parity).
- R6: Every bit lasts exactly N rising edges of `clk` at which `tick_en` is high. N is 1 for `div_sel` 2'b00, 16 for 2'b01 and 64 for 2'b10, counted from the edge at which the bit appears. `tx_busy` falls at the edge that ends the last stop bit.
- R7: `tx_empty` goes low at the edge that samples `load` high. It goes high again at the edge that copies the byte into the shift stage, not at the end of the frame. With the shift stage idle, that copy happens one edge after the load.
- R8: While `cts_n` is high, no new frame starts and the byte stays in the holding register. A frame already in progress runs to its end.
- R9: While `brk` is high, `txd` is 0 and no new frame starts. Once `brk` falls, the line returns to the value it would have without the break.
- R10: A `load` at the same edge that copies the holding register into the shift stage stores the new byte. `tx_empty` stays 0, and that byte is sent as the next frame.
- R11: The format and the bit period are sampled at the edge where a frame starts. Changes to `word_sel` or `div_sel` (other than 2'b11) during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Bit-rate clock enable, counted for bit timing |
| load | input | 1 | Write strobe for the holding register |
| din | input | 8 | Byte to transmit |
| word_sel | input | 3 | Frame format code |
| div_sel | input | 2 | Divide code: 00 /1, 01 /16, 10 /64, 11 hold in reset |
| brk | input | 1 | Force the line to space (0) |
| cts_n | input | 1 | Clear to send, active low; high blocks new frames |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Holding register can accept a byte |
| tx_busy | output | 1 | A frame is being shifted out |

## Verification
A write to the holding register can land in the same cycle in which the previous byte is copied into the shift stage. The bench provokes this by pulsing `load` twice on consecutive edges while the shifter is idle. The outcome is judged by `tx_empty` staying low and by the second byte following the first on the line. In the same way, the end of one frame can meet a `cts_n` or `brk` change or a mid-frame format change. A behavioural bit-queue model is compared against `txd`, `tx_empty` and `tx_busy` on every clock through these collisions.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W   = 8;
    localparam int STOP_MAX = 2;
    localparam int FRAME_W  = 1 + DATA_W + 1 + STOP_MAX;
    localparam int LEN_W    = $clog2(FRAME_W + 1);
    localparam int DIV_MID  = 16;
    localparam int DIV_HI   = 64;
    localparam int DCNT_W   = $clog2(DIV_HI);

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_t;

    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_16  = 2'b01,
        DIV_64  = 2'b10,
        DIV_RST = 2'b11
    } div_t;

    typedef struct packed {
        logic wide;      // 8 data bits when set, 7 otherwise
        par_t par;
        logic two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // bit 0 leaves first
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic fmt_t decode_ws(input logic [2:0] ws);
        fmt_t f;
        case (ws)
            3'b000:  f = '{wide: 1'b0, par: PAR_EVEN, two_stop: 1'b1};
            3'b001:  f = '{wide: 1'b0, par: PAR_ODD,  two_stop: 1'b1};
            3'b010:  f = '{wide: 1'b0, par: PAR_EVEN, two_stop: 1'b0};
            3'b011:  f = '{wide: 1'b0, par: PAR_ODD,  two_stop: 1'b0};
            3'b100:  f = '{wide: 1'b1, par: PAR_NONE, two_stop: 1'b1};
            3'b101:  f = '{wide: 1'b1, par: PAR_NONE, two_stop: 1'b0};
            3'b110:  f = '{wide: 1'b1, par: PAR_EVEN, two_stop: 1'b0};
            default: f = '{wide: 1'b1, par: PAR_ODD,  two_stop: 1'b0};
        endcase
        return f;
    endfunction

    function automatic logic [DCNT_W:0] div_ratio(input logic [1:0] d);
        logic [DCNT_W:0] r;
        case (d)
            DIV_1:   r = (DCNT_W+1)'(1);
            DIV_16:  r = (DCNT_W+1)'(DIV_MID);
            default: r = (DCNT_W+1)'(DIV_HI);
        endcase
        return r;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input fmt_t f);
        frame_t          fr;
        logic [LEN_W-1:0] n;
        logic [DATA_W-1:0] dd;
        logic            p;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        n  = LEN_W'(1);
        dd = d;
        p  = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < DATA_W - 1 || f.wide) begin
                fr.bits[n] = dd[0];
                p = p ^ dd[0];
                n = n + LEN_W'(1);
            end
            dd = dd >> 1;
        end
        if (f.par != PAR_NONE) begin
            fr.bits[n] = (f.par == PAR_ODD) ? ~p : p;
            n = n + LEN_W'(1);
        end
        n = n + (f.two_stop ? LEN_W'(2) : LEN_W'(1));
        fr.len = n;
        return fr;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else begin
            if (load) begin
                full <= 1'b1;
                dout <= din;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    p_load_fills_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> full);

    p_take_frees_r7: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> !full);

endmodule

// File: rtl/sertx_div.sv
module sertx_div
    import sertx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            tick_en,
    input  logic [DCNT_W:0] ratio,
    output logic            bit_tick
);

    logic [DCNT_W-1:0] cnt;

    assign bit_tick = run && tick_en && ({1'b0, cnt} == ratio - (DCNT_W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || bit_tick) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + DCNT_W'(1);
        end
    end

    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> ({1'b0, cnt} < ratio));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  frame_t          frm,
    input  logic [DCNT_W:0] ratio_in,
    input  logic            bit_tick,
    output logic            busy,
    output logic            line,
    output logic [DCNT_W:0] ratio_q
);

    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;

    assign line = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '1;
            left    <= '0;
            busy    <= 1'b0;
            ratio_q <= (DCNT_W+1)'(1);
        end else if (start) begin
            shreg   <= frm.bits;
            left    <= frm.len;
            busy    <= 1'b1;
            ratio_q <= ratio_in;
        end else if (busy && bit_tick) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - LEN_W'(1);
            if (left == LEN_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    p_idle_mark_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line);

    p_busy_has_bits_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left != '0));

    p_ratio_held_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ratio_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       load,
    input  logic [7:0] din,
    input  logic [2:0] word_sel,
    input  logic [1:0] div_sel,
    input  logic       brk,
    input  logic       cts_n,
    output logic       txd,
    output logic       tx_empty,
    output logic       tx_busy
);

    logic              srst;
    logic              full;
    logic [DATA_W-1:0] hold_q;
    logic              start;
    logic              bit_tick;
    logic              line;
    logic [DCNT_W:0]   ratio_q;
    fmt_t              fmt;
    frame_t            frm;

    assign srst  = rst || (div_sel == DIV_RST);
    assign start = !tx_busy && full && !cts_n && !brk;
    assign fmt   = decode_ws(word_sel);
    assign frm   = build_frame(hold_q, fmt);

    sertx_hold u_hold (
        .clk  (clk),
        .rst  (srst),
        .load (load),
        .din  (din),
        .take (start),
        .full (full),
        .dout (hold_q)
    );

    sertx_div u_div (
        .clk      (clk),
        .rst      (srst),
        .run      (tx_busy),
        .tick_en  (tick_en),
        .ratio    (ratio_q),
        .bit_tick (bit_tick)
    );

    sertx_shift u_shift (
        .clk      (clk),
        .rst      (srst),
        .start    (start),
        .frm      (frm),
        .ratio_in (div_ratio(div_sel)),
        .bit_tick (bit_tick),
        .busy     (tx_busy),
        .line     (line),
        .ratio_q  (ratio_q)
    );

    assign txd      = brk ? 1'b0 : line;
    assign tx_empty = !full;

    p_cts_blocks_r8: assert property (@(posedge clk) disable iff (srst)
        (!tx_busy && cts_n) |=> !tx_busy);

    p_brk_blocks_r9: assert property (@(posedge clk) disable iff (srst)
        (!tx_busy && brk) |=> !tx_busy);

    p_start_bit_low_r2: assert property (@(posedge clk) disable iff (srst)
        ($rose(tx_busy) && !brk) |-> !txd);

    p_overlap_keeps_full_r10: assert property (@(posedge clk) disable iff (srst)
        (start && load) |=> !tx_empty);

endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       load = 1'b0;
    logic [7:0] din = 8'h00;
    logic [2:0] word_sel = 3'b101;
    logic [1:0] div_sel = 2'b00;
    logic       brk = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd, tx_empty, tx_busy;

    always #5 clk = ~clk;

    sertx_top uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load(load), .din(din),
        .word_sel(word_sel), .div_sel(div_sel), .brk(brk), .cts_n(cts_n),
        .txd(txd), .tx_empty(tx_empty), .tx_busy(tx_busy)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference: holding flag, bit queue, tick counter
    bit         m_full = 0;
    bit         m_busy = 0;
    logic [7:0] m_hold = 0;
    int         m_q[$];
    int         m_cnt = 0;
    int         m_ratio = 1;
    bit         m_start;

    function automatic void make_frame(input logic [7:0] d, input logic [2:0] ws);
        int nd, stops, ones;
        bit has_par, odd;
        nd      = ws[2] ? 8 : 7;
        has_par = !(ws == 3'b100 || ws == 3'b101);
        odd     = ws[0];
        stops   = (ws == 3'b000 || ws == 3'b001 || ws == 3'b100) ? 2 : 1;
        ones    = 0;
        m_q.delete();
        m_q.push_back(0);
        for (int i = 0; i < nd; i++) begin
            m_q.push_back(int'(d[i]));
            ones += int'(d[i]);
        end
        if (has_par) m_q.push_back(odd ? ((ones % 2 == 0) ? 1 : 0) : (ones % 2));
        for (int i = 0; i < stops; i++) m_q.push_back(1);
    endfunction

    always @(posedge clk) begin
        if (rst || div_sel == 2'b11) begin
            m_full = 0; m_busy = 0; m_cnt = 0; m_q.delete();
        end else begin
            m_start = !m_busy && m_full && !cts_n && !brk;
            if (m_busy && tick_en) begin
                m_cnt++;
                if (m_cnt == m_ratio) begin
                    m_cnt = 0;
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_busy = 0;
                end
            end
            if (m_start) begin
                make_frame(m_hold, word_sel);
                m_busy  = 1;
                m_cnt   = 0;
                m_full  = 0;
                m_ratio = (div_sel == 2'b00) ? 1 : (div_sel == 2'b01) ? 16 : 64;
            end
            if (load) begin
                m_full = 1;
                m_hold = din;
            end
        end
    end

    task automatic check(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (!done) begin
            check(txd, brk ? 1'b0 : (m_busy ? logic'(m_q[0]) : 1'b1), "txd");
            check(tx_empty, !m_full, "tx_empty");
            check(tx_busy, m_busy, "tx_busy");
        end
    end

    always @(negedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en <= (tick_mode == 0) ? 1'b1 : lfsr[0];
    end

    task automatic finish_all();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
            finish_all();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] ws);
        @(negedge clk);
        din = d; word_sel = ws; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tx_empty && !tx_busy) break;
        end
        cyc(2);
    endtask

    initial begin
        cur_req = "R1";                       // reset state
        cyc(3);
        rst = 1'b0;
        cyc(2);

        cur_req = "R2";                       // frame order, 8N1
        send(8'hA5, 3'b101); wait_idle();
        send(8'h3C, 3'b101); wait_idle();

        cur_req = "R3";                       // 7-bit formats
        for (int w = 0; w < 4; w++) begin
            send(8'hD3 ^ 8'(w * 37), 3'(w)); wait_idle();
        end

        cur_req = "R4";                       // 8-bit formats
        for (int w = 4; w < 8; w++) begin
            send(8'h96 ^ 8'(w * 29), 3'(w)); wait_idle();
        end

        cur_req = "R5";                       // parity on assorted bytes
        send(8'h00, 3'b110); wait_idle();
        send(8'hFF, 3'b111); wait_idle();
        send(8'h01, 3'b111); wait_idle();
        send(8'h7F, 3'b000); wait_idle();

        cur_req = "R6";                       // bit periods
        div_sel = 2'b01; tick_mode = 1;
        send(8'h5A, 3'b101); wait_idle();
        div_sel = 2'b10; tick_mode = 0;
        send(8'hC3, 3'b010); wait_idle();
        div_sel = 2'b00;

        cur_req = "R7";                       // empty flag timing
        send(8'h11, 3'b101);
        send(8'h22, 3'b101);
        wait_idle();

        cur_req = "R8";                       // cts gate
        cts_n = 1'b1;
        send(8'h44, 3'b101); cyc(20);
        cts_n = 1'b0; cyc(3);
        cts_n = 1'b1; wait_idle();
        cts_n = 1'b0; cyc(3);

        cur_req = "R9";                       // break
        brk = 1'b1;
        send(8'h66, 3'b101); cyc(15);
        brk = 1'b0; cyc(4);
        brk = 1'b1; cyc(3);
        brk = 1'b0; wait_idle();

        cur_req = "R10";                      // load collides with copy
        @(negedge clk);
        din = 8'h81; word_sel = 3'b101; load = 1'b1;
        @(negedge clk);
        din = 8'h7E;
        @(negedge clk);
        load = 1'b0;
        wait_idle();

        cur_req = "R11";                      // format/divide change mid-frame
        div_sel = 2'b01;
        send(8'h9C, 3'b011); cyc(40);
        word_sel = 3'b100; div_sel = 2'b00; cyc(10);
        div_sel = 2'b10; wait_idle();
        div_sel = 2'b00;

        cur_req = "R1";                       // divide code 11 resets mid-frame
        div_sel = 2'b10;
        send(8'hE7, 3'b100); cyc(100);
        div_sel = 2'b11; cyc(4);
        div_sel = 2'b00; cyc(4);
        send(8'h18, 3'b101); wait_idle();

        finish_all();
    end

endmodule